// File: doc/BRIEF.md
# Multiplexed LED Display Scanner

This block runs a time-multiplexed LED display of up to eight digits with eight segments each, with no help from the host processor. While the display is on, it steps through the digit strobes by itself. At the start of each digit slot it reads that digit's two 4-bit pattern nibbles from a shared data RAM through a synchronous read port. It then drives the assembled pattern on the segment lines while the matching strobe is held. Six strobes are dedicated outputs. The strobes for digits 6 and 7 come out on a separate 2-bit group, which is meant to take over two lines of a general I/O port. The same timing also drives an 8 x 8 dot matrix, with one row or column per strobe.

Software chooses how many digits make up one scan: 4, 5, 6 or 8. A change of length never cuts a scan short. When the display is switched off, every strobe goes low and the segment lines become a plain latched 8-bit output port. The value of that port can be written at any time.

A prescaler sets the slot timing. A slot is `SLOT_TICKS` ticks long and a tick is `PRESC_DIV` clocks long. The first tick of each slot is a blanking gap with all segments dark. The RAM read takes place during this gap.

Top module: `led_scan_ctrl`

## Requirements
- R1: A synchronous reset clears the segment outputs, all strobes and the output-port latch to zero.
- R2: While `disp_en` is high, exactly one strobe is high. Digit k drives bit k of the vector {`dig_aux_o`,`dig_o`}, so digits 0 to 5 appear on `dig_o[0..5]` and digits 6 and 7 appear on `dig_aux_o[0..1]`. Digits are strobed in ascending order and each digit is held for `PRESC_DIV*SLOT_TICKS` clocks.
- R3: `len_sel` sets the scan length. Code 0 gives 4 digits, code 1 gives 5, code 2 gives 6 and code 3 gives 8. After the last digit, the scan returns to digit 0.
- R4: From the second tick of digit k's slot to the end of that slot, `seg_o` equals {RAM[2k+1], RAM[2k]}, with the lower address in bits 3..0.
- R5: During the first `PRESC_DIV` clocks of every slot, `seg_o` is 0.
- R6: A new `len_sel` value written during a scan takes effect only after the last digit of the current scan has finished its slot.
- R7: When `disp_en` is low, all strobes are low. The scan restarts at digit 0, with its blanking tick, on the first clock edge that samples `disp_en` high.
- R8: When `disp_en` is low, `seg_o` shows the port latch. A `port_wr` sampled at an edge loads `port_wdata` into the latch. When the display is off, that same edge also puts the new value on `seg_o`. A write made while the display is on is kept and becomes visible once the display is turned off.
- R9: `rd_en` is high only in the first two clocks of a slot. In the first clock it presents address 2k and in the second it presents 2k+1. The RAM returns the data one clock after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display on (1) or latched output port mode (0) |
| len_sel | input | 2 | Scan length code: 0=4, 1=5, 2=6, 3=8 digits |
| port_wr | input | 1 | Load `port_wdata` into the output-port latch |
| port_wdata | input | 8 | Output-port value |
| rd_en | output | 1 | Pattern RAM read strobe |
| rd_addr | output | 4 | Pattern RAM nibble address |
| rd_data | input | 4 | Pattern RAM data, valid one clock after the read |
| seg_o | output | 8 | Segment lines or latched port value |
| dig_o | output | 6 | Dedicated strobes for digits 0 to 5 |
| dig_aux_o | output | 2 | Strobes for digits 6 and 7 |

## Verification
Segments and strobes are registered. Each one reflects the scan state one edge after that state is reached, so a change of slot appears at the output one clock after the counter wraps. An enable or a port write is visible right after the edge that samples it. The read strobe and the read address follow the scan state in the same cycle. The assembled pattern is stored at the third clock of the blanking tick and is shown from the second tick onward. The bench's behavioural model takes its expected values at each rising edge, and the outputs are compared at the following falling edge. Inputs change one time unit after a rising edge, so every compared value has settled before it is sampled.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int SEG_W   = 8;
  localparam int NIB_W   = 4;
  localparam int MAX_DIG = 8;
  localparam int DED_DIG = 6;
  localparam int DIG_W   = $clog2(MAX_DIG);
  localparam int ADDR_W  = DIG_W + 1;

  typedef enum logic [1:0] {
    LEN_4 = 2'd0,
    LEN_5 = 2'd1,
    LEN_6 = 2'd2,
    LEN_8 = 2'd3
  } scan_len_e;

  function automatic logic [DIG_W-1:0] final_digit(input scan_len_e code);
    case (code)
      LEN_4:   final_digit = DIG_W'(3);
      LEN_5:   final_digit = DIG_W'(4);
      LEN_6:   final_digit = DIG_W'(5);
      default: final_digit = DIG_W'(MAX_DIG - 1);
    endcase
  endfunction
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import led_scan_pkg::*;
#(
  parameter int PRESC_DIV  = 4,
  parameter int SLOT_TICKS = 4,
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 2,
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       len_sel,
  output logic [PW-1:0]    pre_o,
  output logic [TW-1:0]    tick_o,
  output logic [DIG_W-1:0] dig_o
);
  logic [PW-1:0]    pre_q;
  logic [TW-1:0]    tick_q;
  logic [DIG_W-1:0] dig_q;
  scan_len_e        len_q;
  logic             pre_end, tick_end, slot_end;
  logic [DIG_W-1:0] last_dig;

  assign pre_end  = (pre_q == PW'(PRESC_DIV - 1));
  assign tick_end = (tick_q == TW'(SLOT_TICKS - 1));
  assign slot_end = pre_end && tick_end;
  assign last_dig = final_digit(len_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_q  <= '0;
      tick_q <= '0;
      dig_q  <= '0;
      len_q  <= scan_len_e'(len_sel);
    end else begin
      pre_q <= pre_end ? '0 : pre_q + 1'b1;
      if (pre_end) tick_q <= tick_end ? '0 : tick_q + 1'b1;
      if (slot_end) begin
        if (dig_q == last_dig) begin
          dig_q <= '0;
          len_q <= scan_len_e'(len_sel);
        end else begin
          dig_q <= dig_q + 1'b1;
        end
      end
    end
  end

  assign pre_o  = pre_q;
  assign tick_o = tick_q;
  assign dig_o  = dig_q;

  // R3
  dig_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    dig_q <= last_dig);

  // R6
  len_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && en && (len_q != $past(len_q))) |->
      ($past(slot_end) && ($past(dig_q) == $past(last_dig))));
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import led_scan_pkg::*;
#(
  parameter int PW = 2,
  parameter int TW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PW-1:0]     pre_i,
  input  logic [TW-1:0]     tick_i,
  input  logic [DIG_W-1:0]  dig_i,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [NIB_W-1:0]  rd_data,
  output logic [SEG_W-1:0]  pat_o
);
  logic [NIB_W-1:0] lo_q;
  logic [SEG_W-1:0] pat_q;
  logic             in_gap;

  assign in_gap  = en && (tick_i == '0);
  assign rd_en   = in_gap && (pre_i < PW'(2));
  assign rd_addr = {dig_i, pre_i[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      pat_q <= '0;
    end else if (in_gap) begin
      if (pre_i == PW'(1)) lo_q  <= rd_data;
      if (pre_i == PW'(2)) pat_q <= {rd_data, lo_q};
    end
  end

  assign pat_o = pat_q;

  // R4
  pat_gap_only_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_q != $past(pat_q)) |-> ($past(tick_i) == '0));

  // R9
  rd_low_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && (rd_addr[ADDR_W-1:1] == $past(rd_addr[ADDR_W-1:1])))
      |-> (rd_addr[0] && !$past(rd_addr[0])));
endmodule

// File: rtl/scan_out.sv
module scan_out
  import led_scan_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [TW-1:0]      tick_i,
  input  logic [DIG_W-1:0]   dig_i,
  input  logic [SEG_W-1:0]   pat_i,
  input  logic               port_wr,
  input  logic [SEG_W-1:0]   port_wdata,
  output logic [SEG_W-1:0]   seg_o,
  output logic [MAX_DIG-1:0] strb_o
);
  logic [SEG_W-1:0]   latch_q;
  logic [SEG_W-1:0]   seg_q;
  logic [MAX_DIG-1:0] strb_q;
  logic [SEG_W-1:0]   port_val;

  assign port_val = port_wr ? port_wdata : latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      seg_q   <= '0;
      strb_q  <= '0;
    end else begin
      if (port_wr) latch_q <= port_wdata;
      strb_q <= en ? (MAX_DIG'(1) << dig_i) : '0;
      if (!en)                seg_q <= port_val;
      else if (tick_i == '0)  seg_q <= '0;
      else                    seg_q <= pat_i;
    end
  end

  assign seg_o  = seg_q;
  assign strb_o = strb_q;

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> $onehot(strb_q));

  // R7
  strobes_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (strb_q == '0));

  // R8
  port_show_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !port_wr) |=> (seg_q == $past(latch_q)));
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int PRESC_DIV  = 4,
  parameter int SLOT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_en,
  input  logic [1:0]        len_sel,
  input  logic              port_wr,
  input  logic [SEG_W-1:0]  port_wdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [NIB_W-1:0]  rd_data,
  output logic [SEG_W-1:0]  seg_o,
  output logic [DED_DIG-1:0] dig_o,
  output logic [MAX_DIG-DED_DIG-1:0] dig_aux_o
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 2;
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [PW-1:0]      pre;
  logic [TW-1:0]      tick;
  logic [DIG_W-1:0]   dig;
  logic [SEG_W-1:0]   pat;
  logic [MAX_DIG-1:0] strb;

  scan_seq #(.PRESC_DIV(PRESC_DIV), .SLOT_TICKS(SLOT_TICKS)) seq_i (
    .clk(clk), .rst(rst), .en(disp_en), .len_sel(len_sel),
    .pre_o(pre), .tick_o(tick), .dig_o(dig)
  );

  seg_fetch #(.PW(PW), .TW(TW)) fetch_i (
    .clk(clk), .rst(rst), .en(disp_en), .pre_i(pre), .tick_i(tick),
    .dig_i(dig), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pat_o(pat)
  );

  scan_out #(.TW(TW)) out_i (
    .clk(clk), .rst(rst), .en(disp_en), .tick_i(tick), .dig_i(dig),
    .pat_i(pat), .port_wr(port_wr), .port_wdata(port_wdata),
    .seg_o(seg_o), .strb_o(strb)
  );

  assign dig_o     = strb[DED_DIG-1:0];
  assign dig_aux_o = strb[MAX_DIG-1:DED_DIG];

  // R5
  blank_on_switch_chk: assert property (@(posedge clk) disable iff (rst)
    ((strb != '0) && (strb != $past(strb))) |-> (seg_o == '0));
endmodule

// File: tb/led_scan_ctrl_tb_top.sv
module led_scan_ctrl_tb_top;
  localparam int PRESC = 4;
  localparam int TICKS = 4;
  localparam int SLOT  = PRESC * TICKS;

  logic clk = 1'b0, rst = 1'b1, disp_en = 1'b0, port_wr = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic [7:0] port_wdata = 8'h00;
  logic rd_en;
  logic [3:0] rd_addr;
  logic [3:0] rd_data = 4'h0;
  logic [7:0] seg_o;
  logic [5:0] dig_o;
  logic [1:0] dig_aux_o;

  logic [3:0] mem [16];
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  led_scan_ctrl #(.PRESC_DIV(PRESC), .SLOT_TICKS(TICKS)) dut_i (
    .clk(clk), .rst(rst), .disp_en(disp_en), .len_sel(len_sel),
    .port_wr(port_wr), .port_wdata(port_wdata), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .seg_o(seg_o),
    .dig_o(dig_o), .dig_aux_o(dig_aux_o)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  function automatic int last_of(input logic [1:0] c);
    case (c)
      2'd0: return 3;
      2'd1: return 4;
      2'd2: return 5;
      default: return 7;
    endcase
  endfunction

  int m_pos = 0, m_dig = 0, m_last = 3;
  logic [7:0] m_latch = 0, m_pat = 0, e_seg = 0, e_str = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_dig = 0; m_last = last_of(len_sel);
      m_latch = 0; m_pat = 0; e_seg = 0; e_str = 0;
    end else begin
      e_str = disp_en ? 8'(1 << m_dig) : 8'h00;
      if (!disp_en) e_seg = port_wr ? port_wdata : m_latch;
      else          e_seg = (m_pos < PRESC) ? 8'h00 : m_pat;
      if (port_wr) m_latch = port_wdata;
      if (disp_en && m_pos == 2) m_pat = {mem[2*m_dig+1], mem[2*m_dig]};
      if (!disp_en) begin
        m_pos = 0; m_dig = 0; m_last = last_of(len_sel);
      end else if (m_pos == SLOT - 1) begin
        m_pos = 0;
        if (m_dig == m_last) begin
          m_dig = 0; m_last = last_of(len_sel);
        end else m_dig = m_dig + 1;
      end else m_pos = m_pos + 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(32'(seg_o), 32'(e_seg), cur_req, "seg_o");
    chk(32'({dig_aux_o, dig_o}), 32'(e_str), cur_req, "strobes");
    if (!rst) begin
      chk(32'(rd_en), 32'(disp_en && m_pos < 2), "R9", "rd_en");
      if (disp_en && m_pos < 2)
        chk(32'(rd_addr), 32'(2*m_dig + m_pos), "R9", "rd_addr");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic port_write(input logic [7:0] v);
    port_wr = 1'b1; port_wdata = v;
    step(1);
    port_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 4'((i * 7 + 3) % 16);
    step(3);
    cur_req = "R1";
    chk(32'(seg_o), 0, "R1", "seg_o after reset");
    chk(32'({dig_aux_o, dig_o}), 0, "R1", "strobes after reset");
    rst = 1'b0;
    step(2);
    chk(32'(seg_o), 0, "R1", "port latch cleared");

    cur_req = "R8";
    port_write(8'hA5);
    chk(32'(seg_o), 32'h A5, "R8", "port value");
    step(3);
    port_write(8'h3C);
    step(2);

    cur_req = "R2/R3/R4/R5";
    len_sel = 2'd0; disp_en = 1'b1;
    step(2 * 4 * SLOT + 5);

    cur_req = "R6";
    len_sel = 2'd3;
    step(3 * 8 * SLOT);

    cur_req = "R3";
    len_sel = 2'd1;
    step(3 * 8 * SLOT);
    len_sel = 2'd2;
    step(3 * 6 * SLOT);

    cur_req = "R8";
    port_write(8'h5A);
    step(SLOT + 3);

    cur_req = "R7";
    step(SLOT / 2 + 1);
    disp_en = 1'b0;
    step(10);
    chk(32'(seg_o), 32'h5A, "R8", "write made while enabled now shown");
    chk(32'({dig_aux_o, dig_o}), 0, "R7", "strobes off when disabled");
    for (int i = 0; i < 16; i++) mem[i] = 4'(15 - i);
    disp_en = 1'b1;
    step(1);
    chk(32'({dig_aux_o, dig_o}), 1, "R7", "restart at digit 0");
    chk(32'(seg_o), 0, "R7", "restart blank");
    cur_req = "R4";
    step(2 * 6 * SLOT);
    len_sel = 2'd3;
    step(3 * 8 * SLOT);
    disp_en = 1'b0;
    step(4);
    finish_run();
  end
endmodule